// File: doc/BRIEF.md
# UART Receive Status and Timeout Logic

This block is the status side of a serial receiver that has a receive FIFO. Each completed frame from the receive shifter arrives as a data byte plus a parity-error indication and the sampled stop bit. Good frames and frames with errors are both queued. Every entry carries its own overrun, parity and framing flags. Software sees the data and flags of the entry at the head of the queue, so the flags always describe the next byte that a read will return.

The block also tracks line breaks with two bits. One is sticky and stays set until software clears it. The other is live and follows the most recent frame. A latched reception-error status drives an interrupt output through an enable bit. A receive timeout counts bit-clock ticks after the last frame. Its firing rule depends on whether DMA mode is selected, and in DMA mode an error or a timeout raises a halt to the transfer engine. A FIFO-reset input empties the queue. A software-reset request starts a short initialization sequence that clears all state and then drops its busy bit by itself.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the FIFO is empty (fifo_count 0, fifo_empty 1). The outputs eri_flag, err_irq, tout_flag, dma_halt, brk_sticky, brk_live and swrst_busy are all 0, and rd_data with its three status bits reads 0.
- R2: Frames are queued in arrival order. rd_data, st_parity (rx_par_err of that frame) and st_framing (1 when that frame's rx_stop was 0) show the head entry, and they move to the next entry on the cycle after an rd_en pulse.
- R3: A non-break frame that arrives while the FIFO holds DEPTH entries, with no read in the same cycle, is discarded. The newest stored entry then gets its overrun flag (st_overrun) set.
- R4: eri_flag sets on the cycle after a frame with a parity error, a framing error or an overrun. It stays set until an eri_clr pulse. err_irq is eri_flag gated by err_irq_en.
- R5: A frame with all data bits 0 and rx_stop 0 is a break. It is not queued, it counts as a framing error for eri_flag, and it sets both brk_sticky and brk_live.
- R6: brk_live clears when a frame arrives that is not a break. brk_sticky stays set until a brk_clr pulse.
- R7: With dma_mode 0, tout_flag sets on the 2×10 = 20th bit_tick after the last frame only if the FIFO holds at least one byte. With an empty FIFO it stays 0.
- R8: With dma_mode 1, tout_flag sets on the 20th bit_tick after the last frame whether or not the FIFO holds data.
- R9: Each arriving frame, including a break, restarts the 20-tick timeout count from zero. tout_flag is cleared by a tout_clr pulse.
- R10: dma_halt is 1 while dma_mode is 1 and eri_flag or tout_flag is set. The erroneous entries stay in the FIFO with their flags.
- R11: A fifo_rst pulse empties the FIFO on the next cycle.
- R12: A swrst_req pulse sets swrst_busy for 4 cycles, after which it returns to 0 by itself. While it is set, all state is cleared and frames, reads and clears are ignored.
- R13: An rd_en pulse while the FIFO is empty has no effect on the count or on the ordering of later data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per bit time |
| rx_valid | input | 1 | A completed frame is presented this cycle |
| rx_data | input | DATA_W | Received data bits |
| rx_par_err | input | 1 | Parity mismatch on this frame |
| rx_stop | input | 1 | Sampled stop bit (0 = framing error) |
| rd_en | input | 1 | Pop the head entry |
| dma_mode | input | 1 | Selects DMA timeout rule and halt |
| err_irq_en | input | 1 | Reception-error interrupt enable |
| eri_clr | input | 1 | Clear reception-error status |
| tout_clr | input | 1 | Clear timeout status |
| brk_clr | input | 1 | Clear sticky break status |
| fifo_rst | input | 1 | Empty the receive FIFO |
| swrst_req | input | 1 | Request software reset |
| rd_data | output | DATA_W | Head entry data |
| st_overrun | output | 1 | Head entry overrun flag |
| st_parity | output | 1 | Head entry parity flag |
| st_framing | output | 1 | Head entry framing flag |
| fifo_count | output | $clog2(DEPTH+1) | Entries held |
| fifo_empty | output | 1 | FIFO holds no entry |
| eri_flag | output | 1 | Latched reception-error status |
| err_irq | output | 1 | Reception-error interrupt |
| tout_flag | output | 1 | Latched receive timeout |
| dma_halt | output | 1 | Stop request to the DMA engine |
| brk_sticky | output | 1 | Break seen since last clear |
| brk_live | output | 1 | Last frame was a break |
| swrst_busy | output | 1 | Software reset in progress |

## Verification
A flag stored in the wrong FIFO entry shows up only when that entry reaches the head, so the tests pop through every entry and compare the flags byte by byte. A misplaced overrun mark appears on the last read of a full FIFO. A timeout counter that is off by one tick changes tout_flag on tick 19 or 21 instead of 20, so each timeout test samples both sides of the boundary. Reset and clear errors show on the cycle after the pulse, as stale bits or a nonzero count.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

   // Per-entry error flags carried alongside each received byte.
   typedef struct packed {
      logic ovr;
      logic par;
      logic frm;
   } rx_flags_t;

endpackage

// File: rtl/uart_rxs_fifo.sv
module uart_rxs_fifo
   import uart_rxs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  rx_flags_t         wr_flags,
   input  logic              rd_en,
   output logic [DATA_W-1:0] head_data,
   output rx_flags_t         head_flags,
   output logic [CNT_W-1:0]  count,
   output logic              empty,
   output logic              ovr_evt
);

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (DATA_W >= 5) else $error("DATA_W must be at least 5");
   end

   logic [PTR_W-1:0] wptr, rptr, last_idx;
   logic             full, do_rd, do_wr;
   logic [DATA_W-1:0] mem_d [DEPTH];
   rx_flags_t         mem_f [DEPTH];

   assign full     = (count == CNT_W'(DEPTH));
   assign empty    = (count == '0);
   assign do_rd    = rd_en && !empty && !clr;
   assign do_wr    = wr_en && !clr && (!full || do_rd);
   assign ovr_evt  = wr_en && !clr && full && !do_rd;
   assign last_idx = (wptr == '0) ? PTR_W'(DEPTH - 1) : wptr - 1'b1;

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   // One storage slot per entry; the overrun mark lands on the newest slot.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_d[g] <= '0;
            mem_f[g] <= '0;
         end else if (do_wr && wptr == PTR_W'(g)) begin
            mem_d[g] <= wr_data;
            mem_f[g] <= wr_flags;
         end else if (ovr_evt && last_idx == PTR_W'(g)) begin
            mem_f[g].ovr <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wptr <= ptr_inc(wptr);
         if (do_rd) rptr <= ptr_inc(rptr);
         if (do_wr && !do_rd)      count <= count + 1'b1;
         else if (do_rd && !do_wr) count <= count - 1'b1;
      end
   end

   assign head_data  = empty ? '0 : mem_d[rptr];
   assign head_flags = empty ? '0 : mem_f[rptr];

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_full_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en && !clr) |=> (count == $past(count)));

   assert_empty_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty && !wr_en && !clr) |=> (count == '0));

   assert_fifo_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

endmodule

// File: rtl/uart_rxs_timeout.sv
module uart_rxs_timeout #(
   parameter int FRAME_TICKS = 10,
   parameter int FRAMES      = 2,
   localparam int LIMIT = FRAME_TICKS * FRAMES,
   localparam int CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic rx_evt,
   input  logic tick,
   input  logic dma_mode,
   input  logic fifo_nonempty,
   output logic fire
);

   initial begin
      assert (FRAME_TICKS >= 2) else $error("FRAME_TICKS too small");
      assert (FRAMES >= 1) else $error("FRAMES must be positive");
   end

   logic          armed;
   logic [CW-1:0] cnt;
   logic          at_limit, cond_ok;

   assign at_limit = armed && tick && (cnt == CW'(LIMIT - 1));

   // DMA mode fires regardless of FIFO contents; otherwise data is required.
   assign cond_ok = dma_mode || fifo_nonempty;
   assign fire    = at_limit && cond_ok && !rx_evt && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (clr) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (rx_evt) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else if (armed && tick) begin
         if (at_limit) begin
            armed <= 1'b0;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assert_tout_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && !clr) |=> (armed && cnt == '0));

   assert_tout_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(LIMIT));

   assert_tout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !fire);

endmodule

// File: rtl/uart_rxs_swrst.sv
module uart_rxs_swrst #(
   parameter int INIT_CYC = 4,
   localparam int CW = $clog2(INIT_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy
);

   initial begin
      assert (INIT_CYC >= 1) else $error("INIT_CYC must be positive");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         cnt <= '0;
         if (req) busy <= 1'b1;
      end else if (cnt == CW'(INIT_CYC - 1)) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_swrst_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(INIT_CYC));

   assert_swrst_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> busy);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_rxs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 4,
   parameter int FRAME_TICKS = 10,
   parameter int TOUT_FRAMES = 2,
   parameter int INIT_CYC    = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par_err,
   input  logic              rx_stop,
   input  logic              rd_en,
   input  logic              dma_mode,
   input  logic              err_irq_en,
   input  logic              eri_clr,
   input  logic              tout_clr,
   input  logic              brk_clr,
   input  logic              fifo_rst,
   input  logic              swrst_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              st_overrun,
   output logic              st_parity,
   output logic              st_framing,
   output logic [CNT_W-1:0]  fifo_count,
   output logic              fifo_empty,
   output logic              eri_flag,
   output logic              err_irq,
   output logic              tout_flag,
   output logic              dma_halt,
   output logic              brk_sticky,
   output logic              brk_live,
   output logic              swrst_busy
);

   logic      rx_ok, is_brk, frm_err, push, pop, fq_clr;
   logic      ovr_evt, tout_fire, eri_set;
   rx_flags_t in_flags, head_flags;

   // Inputs are ignored while the software reset sequence runs.
   assign rx_ok   = rx_valid && !swrst_busy;
   assign frm_err = !rx_stop;
   assign is_brk  = (rx_data == '0) && frm_err;
   assign push    = rx_ok && !is_brk;
   assign pop     = rd_en && !swrst_busy;
   assign fq_clr  = swrst_busy || fifo_rst;

   assign in_flags.ovr = 1'b0;
   assign in_flags.par = rx_par_err;
   assign in_flags.frm = frm_err;

   uart_rxs_swrst #(.INIT_CYC(INIT_CYC)) u_swrst (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (swrst_req),
      .busy (swrst_busy)
   );

   uart_rxs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fq_clr),
      .wr_en     (push),
      .wr_data   (rx_data),
      .wr_flags  (in_flags),
      .rd_en     (pop),
      .head_data (rd_data),
      .head_flags(head_flags),
      .count     (fifo_count),
      .empty     (fifo_empty),
      .ovr_evt   (ovr_evt)
   );

   uart_rxs_timeout #(.FRAME_TICKS(FRAME_TICKS), .FRAMES(TOUT_FRAMES)) u_tout (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (swrst_busy),
      .rx_evt       (rx_ok),
      .tick         (bit_tick),
      .dma_mode     (dma_mode),
      .fifo_nonempty(!fifo_empty),
      .fire         (tout_fire)
   );

   assign st_overrun = head_flags.ovr;
   assign st_parity  = head_flags.par;
   assign st_framing = head_flags.frm;

   assign eri_set = (rx_ok && (rx_par_err || frm_err)) || ovr_evt;

   // Status bits: set has priority over a software clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eri_flag   <= 1'b0;
         tout_flag  <= 1'b0;
         brk_sticky <= 1'b0;
         brk_live   <= 1'b0;
      end else if (swrst_busy) begin
         eri_flag   <= 1'b0;
         tout_flag  <= 1'b0;
         brk_sticky <= 1'b0;
         brk_live   <= 1'b0;
      end else begin
         if (eri_set)      eri_flag <= 1'b1;
         else if (eri_clr) eri_flag <= 1'b0;

         if (tout_fire)     tout_flag <= 1'b1;
         else if (tout_clr) tout_flag <= 1'b0;

         if (rx_ok && is_brk) brk_sticky <= 1'b1;
         else if (brk_clr)    brk_sticky <= 1'b0;

         if (rx_ok) brk_live <= is_brk;
      end
   end

   assign err_irq  = eri_flag && err_irq_en;
   assign dma_halt = dma_mode && (eri_flag || tout_flag);

   assert_eri_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ok && (rx_par_err || frm_err)) |=> eri_flag);

   assert_brk_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ok && is_brk) |=> (brk_sticky && brk_live));

   assert_live_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ok && !is_brk) |=> !brk_live);

   assert_dma_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_halt && !rd_en && !fifo_rst && !rx_valid && !swrst_req && !swrst_busy)
         |=> (fifo_count == $past(fifo_count)));

   assert_swrst_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_busy |=> (!eri_flag && !brk_sticky && !tout_flag && fifo_empty));

endmodule

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;

   localparam int DW    = 8;
   localparam int DEP   = 4;
   localparam int CW    = $clog2(DEP + 1);
   localparam int TOUT  = 20;
   localparam int INITC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_tick = 0, rx_valid = 0, rx_par_err = 0, rx_stop = 1;
   logic [DW-1:0] rx_data = '0;
   logic          rd_en = 0, dma_mode = 0, err_irq_en = 0;
   logic          eri_clr = 0, tout_clr = 0, brk_clr = 0, fifo_rst = 0, swrst_req = 0;
   logic [DW-1:0] rd_data;
   logic          st_overrun, st_parity, st_framing, fifo_empty;
   logic [CW-1:0] fifo_count;
   logic          eri_flag, err_irq, tout_flag, dma_halt, brk_sticky, brk_live, swrst_busy;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   uart_rx_status #(.DATA_W(DW), .DEPTH(DEP), .FRAME_TICKS(10), .TOUT_FRAMES(2),
                    .INIT_CYC(INITC)) dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_stop(rx_stop),
      .rd_en(rd_en), .dma_mode(dma_mode), .err_irq_en(err_irq_en),
      .eri_clr(eri_clr), .tout_clr(tout_clr), .brk_clr(brk_clr),
      .fifo_rst(fifo_rst), .swrst_req(swrst_req), .rd_data(rd_data),
      .st_overrun(st_overrun), .st_parity(st_parity), .st_framing(st_framing),
      .fifo_count(fifo_count), .fifo_empty(fifo_empty), .eri_flag(eri_flag),
      .err_irq(err_irq), .tout_flag(tout_flag), .dma_halt(dma_halt),
      .brk_sticky(brk_sticky), .brk_live(brk_live), .swrst_busy(swrst_busy)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic frame(input logic [DW-1:0] d, input logic perr, input logic stop);
      @(negedge clk);
      rx_valid = 1; rx_data = d; rx_par_err = perr; rx_stop = stop;
      @(negedge clk);
      rx_valid = 0; rx_data = '0; rx_par_err = 0; rx_stop = 1;
   endtask

   task automatic pop();
      @(negedge clk); rd_en = 1;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); bit_tick = 1;
      end
      @(negedge clk); bit_tick = 0;
   endtask

   task automatic soft_reset();
      @(negedge clk); swrst_req = 1;
      @(negedge clk); swrst_req = 0;
      repeat (INITC) @(negedge clk);
   endtask

   task automatic head_is(input string tag, input logic [DW-1:0] d,
                          input logic o, input logic p, input logic f);
      check({tag, " data"}, 32'(rd_data), 32'(d));
      check({tag, " ovr"}, 32'(st_overrun), 32'(o));
      check({tag, " par"}, 32'(st_parity), 32'(p));
      check({tag, " frm"}, 32'(st_framing), 32'(f));
   endtask

   task automatic t_reset_state();
      check("R1 count", 32'(fifo_count), 0);
      check("R1 empty", 32'(fifo_empty), 1);
      check("R1 flags", {eri_flag, err_irq, tout_flag, dma_halt, brk_sticky, brk_live, swrst_busy}, 0);
      head_is("R1 head", 8'h00, 0, 0, 0);
   endtask

   task automatic t_order_flags();
      frame(8'hA5, 0, 1);
      frame(8'h3C, 1, 1);
      frame(8'h81, 0, 0);
      check("R2 count", 32'(fifo_count), 3);
      head_is("R2 first", 8'hA5, 0, 0, 0);
      pop();
      head_is("R2 second", 8'h3C, 0, 1, 0);
      pop();
      head_is("R2 third", 8'h81, 0, 0, 1);
      pop();
      check("R2 drained", 32'(fifo_empty), 1);
      head_is("R2 empty head", 8'h00, 0, 0, 0);
      soft_reset();
   endtask

   task automatic t_overrun();
      for (int i = 0; i < DEP; i++) frame(8'(8'h10 + i), 0, 1);
      check("R3 no err before", 32'(eri_flag), 0);
      frame(8'h55, 0, 1);
      check("R3 count held", 32'(fifo_count), DEP);
      check("R3 eri", 32'(eri_flag), 1);
      for (int i = 0; i < DEP - 1; i++) begin
         head_is("R3 older", 8'(8'h10 + i), 0, 0, 0);
         pop();
      end
      head_is("R3 newest", 8'h13, 1, 0, 0);
      pop();
      check("R3 drained", 32'(fifo_empty), 1);
      soft_reset();
   endtask

   task automatic t_eri();
      frame(8'h42, 0, 1);
      check("R4 clean", 32'(eri_flag), 0);
      frame(8'h43, 1, 1);
      check("R4 set", 32'(eri_flag), 1);
      check("R4 irq masked", 32'(err_irq), 0);
      @(negedge clk); err_irq_en = 1;
      @(negedge clk);
      check("R4 irq on", 32'(err_irq), 1);
      frame(8'h44, 0, 1);
      check("R4 sticky", 32'(eri_flag), 1);
      @(negedge clk); eri_clr = 1;
      @(negedge clk); eri_clr = 0;
      check("R4 cleared", 32'(eri_flag), 0);
      check("R4 irq off", 32'(err_irq), 0);
      err_irq_en = 0;
      soft_reset();
   endtask

   task automatic t_break();
      frame(8'h00, 0, 0);
      check("R5 not queued", 32'(fifo_count), 0);
      check("R5 sticky", 32'(brk_sticky), 1);
      check("R5 live", 32'(brk_live), 1);
      check("R5 eri", 32'(eri_flag), 1);
      frame(8'h11, 0, 1);
      check("R6 live cleared", 32'(brk_live), 0);
      check("R6 sticky held", 32'(brk_sticky), 1);
      check("R6 queued", 32'(fifo_count), 1);
      @(negedge clk); brk_clr = 1;
      @(negedge clk); brk_clr = 0;
      check("R6 sticky cleared", 32'(brk_sticky), 0);
      soft_reset();
   endtask

   task automatic t_tout_nodma();
      frame(8'h61, 0, 1);
      ticks(TOUT - 1);
      check("R7 before limit", 32'(tout_flag), 0);
      ticks(1);
      check("R7 at limit", 32'(tout_flag), 1);
      check("R7 no halt", 32'(dma_halt), 0);
      pop();
      @(negedge clk); tout_clr = 1;
      @(negedge clk); tout_clr = 0;
      check("R9 cleared", 32'(tout_flag), 0);
      frame(8'h62, 0, 1);
      pop();
      ticks(TOUT + 2);
      check("R7 empty no timeout", 32'(tout_flag), 0);
      soft_reset();
   endtask

   task automatic t_tout_dma();
      dma_mode = 1;
      frame(8'h71, 0, 1);
      pop();
      ticks(TOUT - 1);
      check("R8 before limit", 32'(tout_flag), 0);
      ticks(1);
      check("R8 empty still fires", 32'(tout_flag), 1);
      check("R10 halt on timeout", 32'(dma_halt), 1);
      dma_mode = 0;
      soft_reset();
   endtask

   task automatic t_restart();
      frame(8'h81, 0, 1);
      ticks(15);
      frame(8'h82, 0, 1);
      ticks(15);
      check("R9 restarted", 32'(tout_flag), 0);
      ticks(4);
      check("R9 tick 19", 32'(tout_flag), 0);
      ticks(1);
      check("R9 tick 20", 32'(tout_flag), 1);
      soft_reset();
   endtask

   task automatic t_dma_halt();
      dma_mode = 1;
      frame(8'h20, 1, 1);
      check("R10 halt", 32'(dma_halt), 1);
      repeat (5) @(negedge clk);
      check("R10 data kept", 32'(fifo_count), 1);
      head_is("R10 head", 8'h20, 0, 1, 0);
      @(negedge clk); dma_mode = 0;
      @(negedge clk);
      check("R10 halt off", 32'(dma_halt), 0);
      soft_reset();
   endtask

   task automatic t_fifo_rst();
      frame(8'h91, 0, 1);
      frame(8'h92, 0, 1);
      @(negedge clk); fifo_rst = 1;
      @(negedge clk); fifo_rst = 0;
      check("R11 emptied", 32'(fifo_count), 0);
      check("R11 empty flag", 32'(fifo_empty), 1);
      soft_reset();
   endtask

   task automatic t_empty_read();
      pop();
      check("R13 count", 32'(fifo_count), 0);
      frame(8'hB7, 0, 1);
      check("R13 count after push", 32'(fifo_count), 1);
      head_is("R13 head", 8'hB7, 0, 0, 0);
      soft_reset();
   endtask

   task automatic t_swrst();
      frame(8'h00, 0, 0);
      frame(8'hC1, 1, 1);
      @(negedge clk); swrst_req = 1;
      @(negedge clk); swrst_req = 0;
      check("R12 busy", 32'(swrst_busy), 1);
      rx_valid = 1; rx_data = 8'hD2; rx_stop = 1;
      @(negedge clk);
      rx_valid = 0; rx_data = '0;
      repeat (INITC - 2) @(negedge clk);
      check("R12 busy late", 32'(swrst_busy), 1);
      @(negedge clk);
      check("R12 self clear", 32'(swrst_busy), 0);
      check("R12 fifo", 32'(fifo_count), 0);
      check("R12 flags", {eri_flag, tout_flag, brk_sticky, brk_live}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset_state();
      t_order_flags();
      t_overrun();
      t_eri();
      t_break();
      t_tout_nodma();
      t_tout_dma();
      t_restart();
      t_dma_halt();
      t_fifo_rst();
      t_empty_read();
      t_swrst();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule